// File: doc/BRIEF.md
# Second-Level Cache Configuration Sequencer

This block holds the configuration word of a second-level cache and makes sure that the word can only move through legal states. The processor core reads and writes the word through a simple register port. Each write is checked against the live interface state before it is stored. A write that would turn the cache on before its clock is running and locked is refused. So is a write that starts a global invalidate, or that turns on write-through, while the cache is active. A refused field keeps its old value, and a sticky violation flag records the refusal until software clears it.

From the stored word the block drives the cache's run-time controls. The enable reaches the cache only when the cache unit accepts its next transaction. The clock-ratio code and the DLL enable go to the clock generator. A global-invalidate walker visits every tag entry, one per cycle. The block also applies the data-only, instruction-only and write-through policies to fill and store requests, forces the generated parity to zero when parity is off, and drives the SRAM low-power pin from the nap and sleep states.

Top module: `cache_cfg_seq`

## Requirements
- R1: After reset every output is zero, including the whole readback word, the enable, the busy flag and the low-power pin.
- R2: A write that sets the enable bit (bit 0) while it is clear is accepted only if the stored ratio is nonzero, `dll_locked` is high, no invalidate is running and the same write does not request an invalidate. Otherwise bit 0 stays clear and the violation flag (bit 10) is set.
- R3: `cache_enable` takes the stored enable bit only on the clock edge where `xact_accept` is high, and holds its value otherwise.
- R4: `clk_ratio` shows the stored ratio field (bits 4:2), and `dll_enable` is high exactly when that field is nonzero.
- R5: Writing 1 to bit 7 while both the stored enable bit and `cache_enable` are clear, and no walk is running, starts a walk. `inv_busy` is then high for exactly TAG_ENTRIES cycles, `inv_index` steps 0,1,…,TAG_ENTRIES-1, and bit 7 reads as busy. The same request while the cache is enabled or a walk is running is refused and sets the violation flag.
- R6: Setting write-through (bit 9) from 0 to 1 while the cache is enabled is refused and sets the violation flag. Clearing it is always accepted.
- R7: The violation flag is sticky and is cleared by writing 1 to bit 10. If the same write also causes a new violation, the flag stays set.
- R8: `sram_zz` equals low-power-control (bit 8) AND (`nap_state` OR `sleep_state`), delayed by one cycle.
- R9: `fill_allow` = `cache_enable` & `miss_valid` & (an instruction miss needs data-only (bit 5) clear; a data miss needs instruction-only (bit 6) clear). `bus_forward` = `store_valid` & write-through. `mark_dirty` = `store_valid` & `cache_enable` & !write-through.
- R10: `par_out[i]` is the XOR of byte i of `par_data` when parity enable (bit 1) is set, and 0 when it is clear.
- R11: The parity, ratio, data-only, instruction-only and low-power fields take any written value without restriction and read back unchanged. Bits 0, 7, 9 and 10 read back as enable, busy, write-through and violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 11 | Configuration write data |
| dll_locked | input | 1 | DLL reports stable |
| nap_state | input | 1 | Core is in nap |
| sleep_state | input | 1 | Core is in sleep |
| xact_accept | input | 1 | Cache unit accepts a transaction this cycle |
| miss_valid | input | 1 | A miss requests a fill |
| miss_is_instr | input | 1 | The miss comes from the instruction side |
| store_valid | input | 1 | A store hits the cache |
| par_data | input | DATA_W | Data whose parity is generated |
| cfg_rd_data | output | 11 | Configuration readback |
| cache_enable | output | 1 | Effective cache enable |
| clk_ratio | output | 3 | Clock-ratio code to the clock generator |
| dll_enable | output | 1 | DLL enable |
| inv_busy | output | 1 | Global invalidate walk in progress |
| inv_index | output | log2(TAG_ENTRIES) | Tag entry cleared this cycle |
| write_through | output | 1 | Write-through policy |
| data_only | output | 1 | Data-only allocation policy |
| instr_only | output | 1 | Instruction-only allocation policy |
| parity_en | output | 1 | Parity enable |
| sram_zz | output | 1 | SRAM low-power pin |
| fill_allow | output | 1 | The pending miss may allocate |
| bus_forward | output | 1 | The store is also sent to the system bus |
| mark_dirty | output | 1 | The stored line becomes dirty |
| par_out | output | DATA_W/8 | Generated parity, one bit per byte |

## Verification
Two pairs of checks can fall on the same write. In the first, an enable request and an invalidate request arrive together: the invalidate must start, the enable must be refused, and the violation flag must rise. In the second, a write that clears the violation flag also breaks a rule: the bench sets write-through while the cache is enabled, and also enables with a zero ratio, and expects the flag to stay set. The bench also issues an enable request in the middle of a running walk and checks that the walk still visits every index in order.

// File: rtl/cache_cfg_pkg.sv
package cache_cfg_pkg;
  localparam int B_EN    = 0;
  localparam int B_PAR   = 1;
  localparam int B_RAT   = 2;
  localparam int RAT_W   = 3;
  localparam int B_DO    = 5;
  localparam int B_IO    = 6;
  localparam int B_INV   = 7;
  localparam int B_LP    = 8;
  localparam int B_WT    = 9;
  localparam int B_VIOL  = 10;
  localparam int CFG_W   = 11;

  typedef struct packed {
    logic             viol;
    logic             wt;
    logic             lp;
    logic             iof;
    logic             dof;
    logic [RAT_W-1:0] ratio;
    logic             par;
    logic             en;
  } cfg_t;
endpackage

// File: rtl/cache_cfg_regs.sv
module cache_cfg_regs
  import cache_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             dll_locked,
  input  logic             cache_enable,
  input  logic             inv_busy,
  output cfg_t             cfg,
  output logic             inv_start
);
  cfg_t cfg_q, cfg_d;
  logic enabled, inv_req, inv_ok, en_set, en_ok, wt_set, viol_now;

  always_comb begin
    enabled  = cfg_q.en | cache_enable;
    inv_req  = wr_en & wr_data[B_INV];
    inv_ok   = ~enabled & ~inv_busy;
    en_set   = wr_en & wr_data[B_EN] & ~cfg_q.en;
    en_ok    = (cfg_q.ratio != '0) & dll_locked & ~inv_busy & ~inv_req;
    wt_set   = wr_en & wr_data[B_WT] & ~cfg_q.wt;
    viol_now = (en_set & ~en_ok) | (inv_req & ~inv_ok) | (wt_set & enabled);
    inv_start = inv_req & inv_ok;

    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.par   = wr_data[B_PAR];
      cfg_d.ratio = wr_data[B_RAT +: RAT_W];
      cfg_d.dof   = wr_data[B_DO];
      cfg_d.iof   = wr_data[B_IO];
      cfg_d.lp    = wr_data[B_LP];
      if (!wr_data[B_EN])          cfg_d.en = 1'b0;
      else if (en_set && en_ok)    cfg_d.en = 1'b1;
      if (!wr_data[B_WT])          cfg_d.wt = 1'b0;
      else if (wt_set && !enabled) cfg_d.wt = 1'b1;
      if (viol_now)                cfg_d.viol = 1'b1;
      else if (wr_data[B_VIOL])    cfg_d.viol = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cache_inv_walker.sv
module cache_inv_walker #(
  parameter  int ENTRIES = 256,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] index
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    step   = start | busy_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (step) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy  = busy_q;
  assign index = idx_q;
endmodule

// File: rtl/cache_policy_unit.sv
module cache_policy_unit #(
  parameter  int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              cache_enable,
  input  logic              dof,
  input  logic              iof,
  input  logic              wt,
  input  logic              par_en,
  input  logic              miss_valid,
  input  logic              miss_is_instr,
  input  logic              store_valid,
  input  logic [DATA_W-1:0] par_data,
  output logic              fill_allow,
  output logic              bus_forward,
  output logic              mark_dirty,
  output logic [NBYTES-1:0] par_out
);
  logic side_ok;

  always_comb begin
    side_ok     = miss_is_instr ? ~dof : ~iof;
    fill_allow  = cache_enable & miss_valid & side_ok;
    bus_forward = store_valid & wt;
    mark_dirty  = store_valid & cache_enable & ~wt;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_par
    assign par_out[g] = par_en & (^par_data[g*8 +: 8]);
  end
endmodule

// File: rtl/cache_cfg_seq.sv
module cache_cfg_seq
  import cache_cfg_pkg::*;
#(
  parameter  int TAG_ENTRIES = 256,
  parameter  int DATA_W      = 64,
  localparam int IDX_W       = $clog2(TAG_ENTRIES),
  localparam int NBYTES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  input  logic              dll_locked,
  input  logic              nap_state,
  input  logic              sleep_state,
  input  logic              xact_accept,
  input  logic              miss_valid,
  input  logic              miss_is_instr,
  input  logic              store_valid,
  input  logic [DATA_W-1:0] par_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  output logic              cache_enable,
  output logic [RAT_W-1:0]  clk_ratio,
  output logic              dll_enable,
  output logic              inv_busy,
  output logic [IDX_W-1:0]  inv_index,
  output logic              write_through,
  output logic              data_only,
  output logic              instr_only,
  output logic              parity_en,
  output logic              sram_zz,
  output logic              fill_allow,
  output logic              bus_forward,
  output logic              mark_dirty,
  output logic [NBYTES-1:0] par_out
);
  cfg_t cfg;
  logic inv_start;
  logic ce_q, ce_d;
  logic zz_q, zz_d;

  cache_cfg_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wr_data      (cfg_wr_data),
    .dll_locked   (dll_locked),
    .cache_enable (ce_q),
    .inv_busy     (inv_busy),
    .cfg          (cfg),
    .inv_start    (inv_start)
  );

  cache_inv_walker #(.ENTRIES(TAG_ENTRIES)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (inv_start),
    .busy  (inv_busy),
    .index (inv_index)
  );

  cache_policy_unit #(.DATA_W(DATA_W)) u_pol (
    .cache_enable  (ce_q),
    .dof           (cfg.dof),
    .iof           (cfg.iof),
    .wt            (cfg.wt),
    .par_en        (cfg.par),
    .miss_valid    (miss_valid),
    .miss_is_instr (miss_is_instr),
    .store_valid   (store_valid),
    .par_data      (par_data),
    .fill_allow    (fill_allow),
    .bus_forward   (bus_forward),
    .mark_dirty    (mark_dirty),
    .par_out       (par_out)
  );

  always_comb begin
    ce_d = cfg.en;
    zz_d = cfg.lp & (nap_state | sleep_state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ce_q <= 1'b0;
    else if (xact_accept) ce_q <= ce_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zz_q <= 1'b0;
    else        zz_q <= zz_d;
  end

  always_comb begin
    cfg_rd_data                 = '0;
    cfg_rd_data[B_EN]           = cfg.en;
    cfg_rd_data[B_PAR]          = cfg.par;
    cfg_rd_data[B_RAT +: RAT_W] = cfg.ratio;
    cfg_rd_data[B_DO]           = cfg.dof;
    cfg_rd_data[B_IO]           = cfg.iof;
    cfg_rd_data[B_INV]          = inv_busy;
    cfg_rd_data[B_LP]           = cfg.lp;
    cfg_rd_data[B_WT]           = cfg.wt;
    cfg_rd_data[B_VIOL]         = cfg.viol;
  end

  assign cache_enable  = ce_q;
  assign clk_ratio     = cfg.ratio;
  assign dll_enable    = |cfg.ratio;
  assign write_through = cfg.wt;
  assign data_only     = cfg.dof;
  assign instr_only    = cfg.iof;
  assign parity_en     = cfg.par;
  assign sram_zz       = zz_q;
endmodule

// File: rtl/cache_cfg_seq_chk.sv
module cache_cfg_seq_chk #(
  parameter  int TAG_ENTRIES = 256,
  parameter  int DATA_W      = 64,
  localparam int IDX_W       = $clog2(TAG_ENTRIES),
  localparam int NBYTES      = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dll_locked,
  input logic              nap_state,
  input logic              sleep_state,
  input logic              xact_accept,
  input logic [10:0]       cfg_rd_data,
  input logic              cache_enable,
  input logic [2:0]        clk_ratio,
  input logic              inv_busy,
  input logic [IDX_W-1:0]  inv_index,
  input logic              write_through,
  input logic              data_only,
  input logic              instr_only,
  input logic              parity_en,
  input logic              sram_zz,
  input logic              fill_allow,
  input logic [NBYTES-1:0] par_out
);
  AST_EN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rd_data[0]) |-> ($past(dll_locked) && ($past(clk_ratio) != 3'd0))); // R2
  AST_EN_AT_XACT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cache_enable) |-> $past(xact_accept)); // R3
  AST_WALK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !cache_enable); // R5
  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_busy && $past(inv_busy)) |-> (inv_index == IDX_W'($past(inv_index) + 1'b1))); // R5
  AST_WT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_through) |-> !$past(cache_enable)); // R6
  AST_ZZ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sram_zz == $past(cfg_rd_data[8] & (nap_state | sleep_state))); // R8
  AST_LOCK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (data_only && instr_only) |-> !fill_allow); // R9
  AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_en |-> (par_out == '0)); // R10
endmodule

bind cache_cfg_seq cache_cfg_seq_chk #(.TAG_ENTRIES(TAG_ENTRIES), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dll_locked    (dll_locked),
  .nap_state     (nap_state),
  .sleep_state   (sleep_state),
  .xact_accept   (xact_accept),
  .cfg_rd_data   (cfg_rd_data),
  .cache_enable  (cache_enable),
  .clk_ratio     (clk_ratio),
  .inv_busy      (inv_busy),
  .inv_index     (inv_index),
  .write_through (write_through),
  .data_only     (data_only),
  .instr_only    (instr_only),
  .parity_en     (parity_en),
  .sram_zz       (sram_zz),
  .fill_allow    (fill_allow),
  .par_out       (par_out)
);

// File: tb/cache_cfg_seq_bench.sv
module cache_cfg_seq_bench;
  localparam int N   = 8;
  localparam int DW  = 32;
  localparam int IW  = $clog2(N);
  localparam int NB  = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en;
  logic [10:0] cfg_wr_data;
  logic dll_locked, nap_state, sleep_state, xact_accept;
  logic miss_valid, miss_is_instr, store_valid;
  logic [DW-1:0] par_data;
  logic [10:0] cfg_rd_data;
  logic cache_enable, dll_enable, inv_busy, write_through, data_only, instr_only;
  logic parity_en, sram_zz, fill_allow, bus_forward, mark_dirty;
  logic [2:0] clk_ratio;
  logic [IW-1:0] inv_index;
  logic [NB-1:0] par_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cache_cfg_seq #(.TAG_ENTRIES(N), .DATA_W(DW)) u_cache_cfg_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .dll_locked(dll_locked), .nap_state(nap_state), .sleep_state(sleep_state),
    .xact_accept(xact_accept), .miss_valid(miss_valid), .miss_is_instr(miss_is_instr),
    .store_valid(store_valid), .par_data(par_data), .cfg_rd_data(cfg_rd_data),
    .cache_enable(cache_enable), .clk_ratio(clk_ratio), .dll_enable(dll_enable),
    .inv_busy(inv_busy), .inv_index(inv_index), .write_through(write_through),
    .data_only(data_only), .instr_only(instr_only), .parity_en(parity_en),
    .sram_zz(sram_zz), .fill_allow(fill_allow), .bus_forward(bus_forward),
    .mark_dirty(mark_dirty), .par_out(par_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] mk(input logic en, input logic par, input logic [2:0] rat,
                                     input logic dof, input logic iof, input logic inv,
                                     input logic lp, input logic wt, input logic clr);
    return {clr, wt, lp, inv, iof, dof, rat, par, en};
  endfunction

  task automatic wr(input logic [10:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic xact();
    @(negedge clk);
    xact_accept = 1'b1;
    @(negedge clk);
    xact_accept = 1'b0;
  endtask

  task automatic policy_sweep(input logic ce, input logic wt);
    for (int v = 0; v < 32; v++) begin
      logic dof, iof, mi, ins, st;
      {dof, iof, mi, ins, st} = 5'(v);
      wr(mk(ce, 1'b0, 3'd3, dof, iof, 1'b0, 1'b0, wt, 1'b0));
      miss_valid = mi; miss_is_instr = ins; store_valid = st;
      #1;
      chk("R9 fill_allow", fill_allow, ce & mi & (ins ? ~dof : ~iof));
      chk("R9 bus_forward", bus_forward, st & wt);
      chk("R9 mark_dirty", mark_dirty, st & ce & ~wt);
    end
    miss_valid = 0; miss_is_instr = 0; store_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wr_en = 0; cfg_wr_data = '0; dll_locked = 0; nap_state = 0;
    sleep_state = 0; xact_accept = 0; miss_valid = 0; miss_is_instr = 0;
    store_valid = 0; par_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 readback", cfg_rd_data, 0);
    chk("R1 enable", cache_enable, 0);
    chk("R1 busy", inv_busy, 0);
    chk("R1 zz", sram_zz, 0);
    chk("R1 dll", dll_enable, 0);
    chk("R1 parity", par_out, 0);

    // R11 and R4: free fields, full sweep
    for (int r = 0; r < 8; r++) begin
      for (int f = 0; f < 16; f++) begin
        logic [10:0] w;
        w = mk(1'b0, f[0], 3'(r), f[1], f[2], 1'b0, f[3], 1'b0, 1'b0);
        wr(w);
        chk("R11 readback", cfg_rd_data, w);
        chk("R4 clk_ratio", clk_ratio, r);
        chk("R4 dll_enable", dll_enable, (r != 0));
        chk("R11 flags", {parity_en, data_only, instr_only}, {f[0], f[1], f[2]});
      end
    end

    // R2: enable with zero ratio is refused
    dll_locked = 1;
    wr(mk(0,0,3'd0,0,0,0,0,0,0));
    wr(mk(1,0,3'd0,0,0,0,0,0,0));
    chk("R2 en refused zero ratio", cfg_rd_data[0], 0);
    chk("R2 viol set", cfg_rd_data[10], 1);
    // R7: new violation in the same write as the clear keeps the flag
    wr(mk(1,0,3'd0,0,0,0,0,0,1));
    chk("R7 viol kept on collision", cfg_rd_data[10], 1);
    wr(mk(0,0,3'd0,0,0,0,0,0,1));
    chk("R7 viol cleared", cfg_rd_data[10], 0);
    // R2: enable without lock is refused
    wr(mk(0,0,3'd3,0,0,0,0,0,0));
    dll_locked = 0;
    wr(mk(1,0,3'd3,0,0,0,0,0,0));
    chk("R2 en refused no lock", cfg_rd_data[0], 0);
    chk("R2 viol set no lock", cfg_rd_data[10], 1);
    dll_locked = 1;
    wr(mk(1,0,3'd3,0,0,0,0,0,1));
    chk("R2 en accepted", cfg_rd_data[0], 1);
    chk("R7 viol cleared with legal enable", cfg_rd_data[10], 0);
    // R3: effective enable waits for a transaction
    chk("R3 not yet enabled", cache_enable, 0);
    repeat (3) @(negedge clk);
    chk("R3 still waiting", cache_enable, 0);
    xact();
    chk("R3 enabled after xact", cache_enable, 1);

    // R5: invalidate refused while enabled
    wr(mk(1,0,3'd3,0,0,1,0,0,0));
    chk("R5 inv refused busy", inv_busy, 0);
    chk("R5 inv refused viol", cfg_rd_data[10], 1);
    // R6 with R7 collision
    wr(mk(1,0,3'd3,0,0,0,0,1,1));
    chk("R6 wt refused", write_through, 0);
    chk("R7 viol kept on wt collision", cfg_rd_data[10], 1);
    wr(mk(1,0,3'd3,0,0,0,0,0,1));
    chk("R7 viol cleared", cfg_rd_data[10], 0);

    // R9 with cache enabled, write-back
    policy_sweep(1'b1, 1'b0);

    // R3: disable also waits for a transaction
    wr(mk(0,0,3'd3,0,0,0,0,0,0));
    chk("R3 disable pending", cache_enable, 1);
    xact();
    chk("R3 disabled after xact", cache_enable, 0);
    // R6: write-through accepted while disabled
    wr(mk(0,0,3'd3,0,0,0,0,1,0));
    chk("R6 wt accepted", write_through, 1);
    chk("R6 no viol", cfg_rd_data[10], 0);
    policy_sweep(1'b0, 1'b1);
    wr(mk(0,0,3'd3,0,0,0,0,0,0));
    chk("R6 wt clear", write_through, 0);

    // R5 and R2 collision: enable plus invalidate in one write
    wr(mk(1,0,3'd3,0,0,1,0,0,0));
    chk("R2 en refused with inv", cfg_rd_data[0], 0);
    chk("R2 viol on collision", cfg_rd_data[10], 1);
    for (int k = 0; k < N; k++) begin
      chk("R5 busy during walk", inv_busy, 1);
      chk("R5 index", inv_index, k);
      chk("R5 busy readback", cfg_rd_data[7], 1);
      @(negedge clk);
    end
    chk("R5 walk done", inv_busy, 0);
    chk("R5 busy readback clear", cfg_rd_data[7], 0);
    wr(mk(0,0,3'd3,0,0,0,0,0,1));
    // R2: enable during a running walk
    wr(mk(0,0,3'd3,0,0,1,0,0,0));
    chk("R5 walk start", inv_busy, 1);
    wr(mk(1,0,3'd3,0,0,0,0,0,0));
    chk("R2 en refused during walk", cfg_rd_data[0], 0);
    chk("R2 viol during walk", cfg_rd_data[10], 1);
    chk("R5 walk index advances", inv_index, 2);
    while (inv_busy) @(negedge clk);
    wr(mk(0,0,3'd3,0,0,0,0,0,1));

    // R8 low-power pin
    for (int v = 0; v < 8; v++) begin
      wr(mk(0,0,3'd3,0,0,0,v[2],0,0));
      @(negedge clk);
      nap_state = v[0]; sleep_state = v[1];
      @(negedge clk);
      chk("R8 sram_zz", sram_zz, v[2] & (v[0] | v[1]));
    end
    nap_state = 0; sleep_state = 0;

    // R10 parity generation
    for (int p = 0; p < 2; p++) begin
      wr(mk(0,p[0],3'd3,0,0,0,0,0,0));
      for (int s = 0; s < 40; s++) begin
        logic [NB-1:0] e;
        par_data = DW'(32'h9E3779B9 * (s + 1)) ^ DW'(s << 3);
        #1;
        for (int b = 0; b < NB; b++) e[b] = p[0] & (^par_data[b*8 +: 8]);
        chk("R10 parity", par_out, e);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule